// File: doc/BRIEF.md
# Compare-Channel System Timer

This block is a system timer with one 64-bit up-counter that never stops on its own and a set of independent compare channels, four by default. Each channel holds a 32-bit compare word that is matched only against the lower 32 bits of the counter. When the counter steps onto a channel's compare word, that channel latches a match flag. Each flag drives its own interrupt line to the interrupt controller, which is outside this block.

Software reaches the timer over a simple word-addressed register port. The port can read both halves of the counter, read and write every compare word, and read the flag word. Writing a one to a flag bit clears that flag. The counter advances only on cycles where the tick-enable input is high, so any prescaling is done upstream.

The register index is byte address bits [4:2]:

| Byte address | Register |
|---|---|
| 0x00 | flag word (one bit per channel) |
| 0x04 | counter bits [31:0] |
| 0x08 | counter bits [63:32] |
| 0x0C + 4*i | compare word of channel i |

Top module: `sys_cmp_timer`

## Requirements
- R1: Reset state. After reset the counter holds the parameter CNT_INIT (zero by default), every compare word is zero, every flag is clear, and `irq` is zero.
- R2: Counting.
  - The counter increases by one at every clock edge where `tick_en` is high, and holds its value otherwise.
  - A carry out of bit 31 increments bits [63:32].
  - The counter wraps from all-ones to zero.
  - Address 0x04 reads counter bits [31:0] and address 0x08 reads bits [63:32].
- R3: The compare word of channel i is written and read back at byte address 0x0C + 4*i.
- R4: Flag setting.
  - Flag i sets at the clock edge where the lower 32 counter bits step onto compare word i.
  - `irq[i]` is the level of flag i, so it is high from the cycle in which the counter shows the matching value.
- R5: Once set, a flag and its `irq` bit stay high while the counter moves past the compare value, until software clears the flag.
- R6: Flag word at 0x00.
  - Bit i of the flag word reads flag i, and the upper bits read zero.
  - Writing the flag word clears each flag whose bit is 1.
  - A 0 bit in that write leaves its flag unchanged.
- R7: If a clear of flag i and a new match on channel i fall in the same cycle, the flag ends up set.
- R8: Compare timing.
  - A compare word equal to the counter does not match while the counter stands still.
  - A compare word written to the current counter value does not match until the counter next arrives at that value.
  - A match in the cycle of a compare write is judged against the old compare word.
- R9: Ignored accesses.
  - Writes to 0x04, 0x08 or an unmapped index, and any access whose address bits [1:0] are not zero, change no state.
  - Reads of unmapped or misaligned addresses return zero.
- R10: Read timing. `bus_rdata` takes the addressed value at the clock edge where `bus_rd` is high, and keeps it at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Counter advance enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W (5) | Byte address |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Registered read data |
| irq | output | N_CH (4) | Per-channel interrupt, level of its match flag |

## Verification
A software clear of a flag and a fresh match on the same channel can land on one clock edge. The bench provokes this by parking the counter one step before a compare value. It then issues the flag-word write in the very cycle that `tick_en` carries the counter onto that value, while the same write clears a second, untouched flag. The result is judged at `irq`: the matching channel must stay set and the other channel must drop. A similar collision writes a new compare word in the cycle the counter advances, and the bench expects no spurious match from the new value.

// File: rtl/stc_pkg.sv
`timescale 1ns/1ps
package stc_pkg;
  // Register index = byte address [ADDR_W-1:2]
  localparam int IDX_FLAGS    = 0;
  localparam int IDX_CNT_LO   = 1;
  localparam int IDX_CNT_HI   = 2;
  localparam int IDX_CMP_BASE = 3;

  // Number of mapped register slots for a given channel count
  function automatic int reg_slots(input int n_ch);
    return IDX_CMP_BASE + n_ch;
  endfunction
endpackage

// File: rtl/stc_counter.sv
`timescale 1ns/1ps
module stc_counter #(
  parameter int                      DATA_W   = 32,
  parameter logic [2*DATA_W-1:0]     CNT_INIT = '0
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_en,
  output logic [2*DATA_W-1:0]   cnt_q,
  output logic [DATA_W-1:0]     lo_next,
  output logic                  step
);
  localparam int CNT_W = 2 * DATA_W;

  logic [DATA_W-1:0] lo_q, hi_q, lo_d, hi_d, lo_inc, hi_inc;
  logic              lo_carry;

  // next-state: split increment, carry from the low half into the high half
  always_comb begin
    lo_inc   = lo_q + DATA_W'(1);
    lo_carry = &lo_q;
    hi_inc   = hi_q + DATA_W'(1);
    lo_d     = lo_q;
    hi_d     = hi_q;
    if (tick_en) begin
      lo_d = lo_inc;
      if (lo_carry) hi_d = hi_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= CNT_INIT[DATA_W-1:0];
      hi_q <= CNT_INIT[CNT_W-1:DATA_W];
    end else if (tick_en) begin
      lo_q <= lo_d;
      hi_q <= hi_d;
    end
  end

  assign cnt_q   = {hi_q, lo_q};
  assign lo_next = lo_inc;
  assign step    = tick_en;

  // R2: counter is frozen without a tick
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> $stable(cnt_q));
  // R2: counter advances by exactly one per tick, modulo 2^CNT_W
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/stc_channel.sv
`timescale 1ns/1ps
module stc_channel #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmp_we,
  input  logic [DATA_W-1:0] cmp_wdata,
  input  logic              flag_clr,
  input  logic              step,
  input  logic [DATA_W-1:0] lo_next,
  output logic [DATA_W-1:0] cmp_q,
  output logic              flag_q
);
  logic [DATA_W-1:0] cmp_d;
  logic              flag_d;
  logic              arrive;

  // A match is an arrival: the counter steps onto the compare value.
  // The compare value in use is the registered one, so a write in the
  // same cycle only affects later arrivals.
  always_comb begin
    arrive = step && (lo_next == cmp_q);
    cmp_d  = cmp_we ? cmp_wdata : cmp_q;
    flag_d = arrive | (flag_q & ~flag_clr);   // set wins over clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmp_q <= '0;
    else if (cmp_we) cmp_q <= cmp_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  // R3: compare word only changes on a write
  p_cmp_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_we |=> $stable(cmp_q));
  // R5: a set flag is kept until cleared
  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  // R6: a clear without counter movement empties the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !step) |=> !flag_q);
  // R8: a stationary counter cannot change a flag
  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !flag_clr) |=> $stable(flag_q));
endmodule

// File: rtl/stc_regbus.sv
`timescale 1ns/1ps
module stc_regbus
  import stc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int N_CH   = 4,
  parameter int ADDR_W = $clog2(reg_slots(N_CH)) + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bus_rd,
  input  logic                          bus_wr,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [DATA_W-1:0]             bus_wdata,
  input  logic [2*DATA_W-1:0]           cnt,
  input  logic [N_CH-1:0][DATA_W-1:0]   cmps,
  input  logic [N_CH-1:0]               flags,
  output logic [N_CH-1:0]               cmp_we,
  output logic [N_CH-1:0]               flag_clr,
  output logic [DATA_W-1:0]             bus_rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]  idx;
  logic              aligned;
  logic [DATA_W-1:0] rd_mux, rdata_d, rdata_q;
  logic [N_CH-1:0]   cmp_hit;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  for (genvar i = 0; i < N_CH; i++) begin : g_sel
    assign cmp_hit[i] = aligned && (idx == IDX_W'(IDX_CMP_BASE + i));
    assign cmp_we[i]  = bus_wr && cmp_hit[i];
  end

  always_comb begin
    flag_clr = '0;
    if (bus_wr && aligned && (idx == IDX_W'(IDX_FLAGS)))
      flag_clr = bus_wdata[N_CH-1:0];
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (idx == IDX_W'(IDX_FLAGS))  rd_mux[N_CH-1:0] = flags;
      if (idx == IDX_W'(IDX_CNT_LO)) rd_mux = cnt[DATA_W-1:0];
      if (idx == IDX_W'(IDX_CNT_HI)) rd_mux = cnt[2*DATA_W-1:DATA_W];
    end
    for (int i = 0; i < N_CH; i++)
      if (cmp_hit[i]) rd_mux = cmps[i];
  end

  assign rdata_d = bus_rd ? rd_mux : rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rdata_d;
  end

  assign bus_rdata = rdata_q;

  // R10: read data only changes on a read strobe
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R6: at most the status index produces clears
  p_clr_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |-> (flag_clr == '0 && cmp_we == '0));
endmodule

// File: rtl/sys_cmp_timer.sv
`timescale 1ns/1ps
module sys_cmp_timer
  import stc_pkg::*;
#(
  parameter int                  DATA_W   = 32,
  parameter int                  N_CH     = 4,
  parameter int                  ADDR_W   = $clog2(reg_slots(N_CH)) + 2,
  parameter logic [2*DATA_W-1:0] CNT_INIT = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [N_CH-1:0]   irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]                 rst_pipe;
  logic                       rst_n_s;
  logic [CNT_W-1:0]           cnt;
  logic [DATA_W-1:0]          lo_next;
  logic                       step;
  logic [N_CH-1:0][DATA_W-1:0] cmps;
  logic [N_CH-1:0]            flags, cmp_we, flag_clr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  stc_counter #(.DATA_W(DATA_W), .CNT_INIT(CNT_INIT)) u_cnt (
    .clk(clk), .rst_n(rst_n_s), .tick_en(tick_en),
    .cnt_q(cnt), .lo_next(lo_next), .step(step)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    stc_channel #(.DATA_W(DATA_W)) u_ch (
      .clk(clk), .rst_n(rst_n_s),
      .cmp_we(cmp_we[i]), .cmp_wdata(bus_wdata),
      .flag_clr(flag_clr[i]), .step(step), .lo_next(lo_next),
      .cmp_q(cmps[i]), .flag_q(flags[i])
    );
  end

  stc_regbus #(.DATA_W(DATA_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n_s),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .cnt(cnt), .cmps(cmps), .flags(flags),
    .cmp_we(cmp_we), .flag_clr(flag_clr), .bus_rdata(bus_rdata)
  );

  assign irq = flags;

  // R1: nothing is pending while in reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n_s |=> (irq == '0 || !rst_n_s));
endmodule

// File: tb/sys_cmp_timer_test.sv
`timescale 1ns/1ps
module sys_cmp_timer_test;
  localparam int          DATA_W = 32;
  localparam int          N_CH   = 4;
  localparam int          ADDR_W = 5;
  localparam logic [63:0] INIT   = 64'hFFFF_FFFF_FFFF_FFF0;

  logic              clk = 1'b0;
  logic              rst_n, tick_en, bus_rd, bus_wr;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata, bus_rdata;
  logic [N_CH-1:0]   irq;

  always #4 clk = ~clk;   // 125 MHz

  sys_cmp_timer #(.DATA_W(DATA_W), .N_CH(N_CH), .ADDR_W(ADDR_W), .CNT_INIT(INIT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] exp;
    string             tag;
  } rd_item_t;

  rd_item_t sb_q[$];
  int       n_chk = 0;
  int       n_err = 0;
  logic     rd_seen = 1'b0;

  // scoreboard monitor: a read strobe seen at an edge is judged at the next negedge
  always @(posedge clk) rd_seen <= bus_rd;

  always @(negedge clk) begin
    rd_item_t it;
    if (rd_seen) begin
      n_chk++;
      if (sb_q.size() == 0) begin
        n_err++;
        $display("FAIL R10: unexpected read data actual 0x%08h expected no data", bus_rdata);
      end else begin
        it = sb_q.pop_front();
        if (bus_rdata !== it.exp) begin
          n_err++;
          $display("FAIL %s: read 0x%02h actual 0x%08h expected 0x%08h",
                   it.tag, it.addr, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic summary();
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog (all): actual timeout, expected completion");
    summary();
  end

  // drivers: called at a negedge, return at a negedge
  task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input logic tk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; tick_en = tk;
    @(negedge clk);
    bus_wr = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] e, input string tag);
    rd_item_t it;
    it.addr = a; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic run(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_irq(input logic [N_CH-1:0] e, input string tag);
    n_chk++;
    if (irq !== e) begin
      n_err++;
      $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1: reset state
    chk_irq(4'b0000, "R1");
    rd(5'h00, 32'h0, "R1");
    rd(5'h04, 32'hFFFF_FFF0, "R1");
    rd(5'h08, 32'hFFFF_FFFF, "R1");
    rd(5'h0C, 32'h0, "R1");
    rd(5'h18, 32'h0, "R1");

    // R2: counting only while tick_en is high
    run(5);
    idle(2);
    rd(5'h04, 32'hFFFF_FFF5, "R2");

    // R9: counter and unmapped writes ignored, odd reads give zero
    wr(5'h04, 32'h0000_1234, 1'b0);
    wr(5'h08, 32'h0, 1'b0);
    wr(5'h1C, 32'hFFFF, 1'b0);
    wr(5'h0D, 32'hFFFF_FFF9, 1'b0);
    rd(5'h04, 32'hFFFF_FFF5, "R9");
    rd(5'h08, 32'hFFFF_FFFF, "R9");
    rd(5'h1C, 32'h0, "R9");
    rd(5'h0D, 32'h0, "R9");
    rd(5'h0C, 32'h0, "R9");

    // R8: compare equal to a stationary counter does not match
    wr(5'h0C, 32'hFFFF_FFF5, 1'b0);
    idle(3);
    chk_irq(4'b0000, "R8");

    // R3: compare words read back
    wr(5'h10, 32'hFFFF_FFF8, 1'b0);
    wr(5'h14, 32'h0000_0002, 1'b0);
    wr(5'h18, 32'hFFFF_FFF6, 1'b0);
    rd(5'h0C, 32'hFFFF_FFF5, "R3");
    rd(5'h10, 32'hFFFF_FFF8, "R3");
    rd(5'h14, 32'h0000_0002, "R3");
    rd(5'h18, 32'hFFFF_FFF6, "R3");

    // R4: arrivals set flags; R5: flags persist
    run(1);
    chk_irq(4'b1000, "R4");
    run(2);
    chk_irq(4'b1010, "R4");
    run(1);
    chk_irq(4'b1010, "R5");

    // R6: write-one clears, write-zero keeps
    wr(5'h00, 32'h0000_0002, 1'b0);
    chk_irq(4'b1000, "R6");
    wr(5'h00, 32'h0, 1'b0);
    chk_irq(4'b1000, "R6");
    rd(5'h00, 32'h0000_0008, "R6");

    // R2: full wrap of both halves (0x..F9 + 7)
    run(7);
    rd(5'h04, 32'h0, "R2");
    rd(5'h08, 32'h0, "R2");
    run(2);
    chk_irq(4'b1100, "R4");
    rd(5'h00, 32'h0000_000C, "R6");

    // R7: clear and arrival on channel 2 in the same cycle
    wr(5'h00, 32'h0000_0004, 1'b0);
    chk_irq(4'b1000, "R6");
    wr(5'h14, 32'h0000_0003, 1'b0);
    wr(5'h00, 32'h0000_000C, 1'b1);
    chk_irq(4'b0100, "R7");

    // R8: compare written in the arrival cycle uses the old value
    wr(5'h0C, 32'h0000_0004, 1'b1);
    chk_irq(4'b0100, "R8");
    idle(2);
    chk_irq(4'b0100, "R8");
    run(1);
    chk_irq(4'b0100, "R8");
    wr(5'h0C, 32'h0000_0006, 1'b0);
    run(1);
    chk_irq(4'b0101, "R4");

    // R10: read data holds without a strobe
    rd(5'h04, 32'h0000_0006, "R10");
    run(1);
    idle(1);
    n_chk++;
    if (bus_rdata !== 32'h0000_0006) begin
      n_err++;
      $display("FAIL R10: held rdata actual 0x%08h expected 0x%08h", bus_rdata, 32'h6);
    end

    idle(3);
    summary();
  end
endmodule